// File: doc/BRIEF.md
# Synchronous DRAM Write-Burst Sequencer

This block is the device-side write path of a synchronous DRAM column array. On every rising clock edge it samples the active-low strobes for chip select, row strobe, column strobe and write enable. When these strobes form a write command, the block does three things on that same edge:

- it takes the column address as the start of a burst;
- it stores the word present on the data bus;
- it keeps storing one word per edge until the programmed burst length has been written.

Column addresses within a burst count upward and wrap inside the aligned group of burst-length columns. A new write command that arrives before a burst finishes abandons the rest of the old burst and starts a full burst at the new column. Any other strobe pattern, including a deselected cycle, is treated as idle and lets a running burst continue.

The burst length is a static selection input. A registered read port exposes the array contents, and the testbench uses it to check what was stored.

Top module: `sdr_wr_burst`

## Requirements
- R1: A write is recognised only when cs_n=0, ras_n=1, cas_n=0 and we_n=0 at a rising edge. Any other pattern seen while idle leaves the array unchanged.
- R2: The col_addr value sampled together with the write command is the first column of the burst.
- R3: The word on dq_in at the edge of the write command is stored at the start column on that same edge.
- R4: Each following edge of the burst stores dq_in at the next column. The low log2(length) address bits count up and wrap, and the upper bits stay fixed.
- R5: After the last word of a burst, busy is 0 and later dq_in values do not modify the array.
- R6: A write command during a burst ends the old burst. Columns of the old burst that were not yet reached are not written, and the new burst runs for the full length from its own start column.
- R7: When two write commands are one clock apart, exactly one word of the first burst is stored, followed by the complete second burst.
- R8: Non-write commands (read, activate, precharge patterns, or cs_n=1) during a burst do not interrupt it.
- R9: blen_sel selects the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8. busy is 1 between the write edge and the final word of a burst longer than one word.
- R10: A synchronous active-high rst clears busy and halts any burst. The array contents are kept across reset.
- R11: rd_data shows the array word at rd_addr one clock after rd_addr is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col_addr | input | 8 | Column address sampled with a write |
| dq_in | input | 16 | Write data bus |
| blen_sel | input | 2 | Burst length code (1/2/4/8) |
| rd_addr | input | 8 | Read-back column |
| rd_data | output | 16 | Registered read-back word |
| busy | output | 1 | Burst in progress after the first word |

## Verification
The array is first filled with back-to-back eight-word bursts, so that any stray write shows up as a changed word. Four-word bursts start at unaligned columns, which separates sequential wrap from plain linear counting. Write pairs spaced one and two clocks apart show whether the remaining old addresses are dropped or written anyway. Runs of data that continue after a burst has ended, and idle-type commands placed mid-burst, separate correct idling from spurious writes or early termination. Bursts of one, two and eight words, and a reset in the middle of a burst, cover the length decode and the rule that reset leaves the stored data in place.

// File: rtl/sdr_wr_pkg.sv
package sdr_wr_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_OTHER = 2'd2
  } sdr_cmd_e;

  // burst length code n selects 2**n words
  function automatic int unsigned blen_words(input int unsigned code);
    return 32'd1 << code;
  endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_wr_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output sdr_cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_IDLE;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_IDLE;
        3'b100:  cmd = CMD_WRITE;
        default: cmd = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl #(
  parameter int COL_W     = 8,
  parameter int BL_LOG2   = 3,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [SEL_W-1:0] len_code,
  output logic             wr_en,
  output logic [COL_W-1:0] wr_col,
  output logic             busy
);

  localparam int CNT_W = BL_LOG2 + 1;

  logic             busy_q;
  logic [COL_W-1:0] base_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_words;
  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] step_col;

  always_comb begin
    len_words = CNT_W'(sdr_wr_pkg::blen_words(32'(len_code)));
    wrap_mask = COL_W'(len_words - 1'b1);
    step_col  = (base_q & ~wrap_mask) |
                ((base_q + COL_W'(cnt_q)) & wrap_mask);
    wr_en     = !rst && (start || busy_q);
    wr_col    = start ? start_col : step_col;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (start) begin
      base_q <= start_col;
      cnt_q  <= CNT_W'(1);
      busy_q <= (len_words != CNT_W'(1));
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q + 1'b1 == len_words) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/sdr_col_array.sv
module sdr_col_array #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_word
);

  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_col] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    rd_word <= mem[rd_col];
  end

endmodule

// File: rtl/sdr_wr_burst.sv
module sdr_wr_burst
  import sdr_wr_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int BL_LOG2 = 3,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [DATA_W-1:0] dq_in,
  input  logic [SEL_W-1:0]  blen_sel,
  input  logic [COL_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);

  sdr_cmd_e         cmd;
  logic             wr_en;
  logic [COL_W-1:0] wr_col;

  sdr_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  sdr_burst_ctrl #(
    .COL_W   (COL_W),
    .BL_LOG2 (BL_LOG2),
    .SEL_W   (SEL_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (cmd == CMD_WRITE),
    .start_col (col_addr),
    .len_code  (blen_sel),
    .wr_en     (wr_en),
    .wr_col    (wr_col),
    .busy      (busy)
  );

  sdr_col_array #(
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_col  (wr_col),
    .wr_data (dq_in),
    .rd_col  (rd_addr),
    .rd_word (rd_data)
  );

endmodule

// File: rtl/sdr_wr_burst_chk.sv
module sdr_wr_burst_chk #(
  parameter int COL_W = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [COL_W-1:0] col_addr,
  input logic [SEL_W-1:0] blen_sel,
  input logic             wr_en,
  input logic [COL_W-1:0] wr_col,
  input logic             busy
);

  logic             wr_pins;
  logic [5:0]       run_q;
  logic [5:0]       len_w;
  logic [COL_W-1:0] msk;

  assign wr_pins = !cs_n && ras_n && !cas_n && !we_n;
  assign len_w   = 6'd1 << blen_sel;
  assign msk     = COL_W'(len_w - 6'd1);

  // words stored since the last write command, kept apart from the design
  always_ff @(posedge clk) begin
    if (rst)          run_q <= '0;
    else if (wr_pins) run_q <= 6'd1;
    else if (wr_en)   run_q <= run_q + 6'd1;
  end

  // R1 R2 R3
  a_r3_cmd_writes_start: assert property (@(posedge clk) disable iff (rst)
    wr_pins |-> (wr_en && wr_col == col_addr));

  // R5 R8
  a_r5_idle_no_store: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wr_pins) |-> !wr_en);

  // R4
  a_r4_seq_wrap: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && wr_en && !wr_pins) |->
      (((wr_col & msk) == (($past(wr_col) + 1'b1) & msk)) &&
       ((wr_col & ~msk) == ($past(wr_col) & ~msk))));

  // R9
  a_r9_len_bound: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_pins) |-> (run_q < len_w));

  // R10
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> !busy);

endmodule

bind sdr_wr_burst sdr_wr_burst_chk #(
  .COL_W (COL_W),
  .SEL_W (SEL_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .col_addr (col_addr),
  .blen_sel (blen_sel),
  .wr_en    (wr_en),
  .wr_col   (wr_col),
  .busy     (busy)
);

// File: tb/test_sdr_wr_burst.sv
`timescale 1ns/1ps
module test_sdr_wr_burst;

  localparam logic [3:0] P_WR    = 4'b0100;
  localparam logic [3:0] P_NOP   = 4'b0111;
  localparam logic [3:0] P_DESEL = 4'b1100;
  localparam logic [3:0] P_RD    = 4'b0101;
  localparam logic [3:0] P_ACT   = 4'b0011;
  localparam logic [3:0] P_PRE   = 4'b0010;

  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [7:0]  col_addr;
  logic [15:0] dq_in;
  logic [1:0]  blen_sel;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic        busy;

  logic [15:0] model [256];
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  sdr_wr_burst i_sdr_wr_burst (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .col_addr(col_addr), .dq_in(dq_in), .blen_sel(blen_sel),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  task automatic cyc(input logic [3:0] p, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = p;
    col_addr = a;
    dq_in    = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s busy actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    int errs = 0;
    cyc(P_NOP, 8'h00, 16'hDEAD);
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      rd_addr = 8'(c);
      @(negedge clk);
      if (rd_data !== model[c]) begin
        errs++;
        if (errs <= 4)
          $display("FAIL %s col=%0h actual=%h expected=%h", req, c, rd_data, model[c]);
      end
    end
    total++;
    if (errs != 0) bad++;
  endtask

  // R4 R9 R11: fill the array with back-to-back eight-word bursts
  task automatic t_fill;
    blen_sel = 2'd3;
    for (int b = 0; b < 32; b++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] c = 8'(b * 8 + k);
        cyc(k == 0 ? P_WR : P_NOP, c, 16'hA000 | 16'(c));
        model[c] = 16'hA000 | 16'(c);
      end
    end
    check_bit("R9", busy, 1'b0);
    check_all("R4 R11 fill");
  endtask

  // R2 R3 R4 R5: unaligned four-word burst wraps, trailing data ignored
  task automatic t_bl4_wrap;
    logic [7:0] cols [4] = '{8'h12, 8'h13, 8'h10, 8'h11};
    blen_sel = 2'd2;
    for (int k = 0; k < 4; k++) begin
      cyc(k == 0 ? P_WR : P_NOP, 8'h12, 16'h4100 + 16'(k));
      model[cols[k]] = 16'h4100 + 16'(k);
      if (k == 0) check_bit("R9", busy, 1'b1);
    end
    check_bit("R5", busy, 1'b0);
    for (int k = 0; k < 3; k++) cyc(P_NOP, 8'h14, 16'hBAD0 + 16'(k));
    check_all("R2 R3 R4 R5 bl4");
  endtask

  // R6 R7: second write one clock later
  task automatic t_gap1;
    blen_sel = 2'd2;
    cyc(P_WR, 8'h20, 16'h5A00);
    model[8'h20] = 16'h5A00;
    for (int k = 0; k < 4; k++) begin
      cyc(k == 0 ? P_WR : P_NOP, 8'h40, 16'h5B00 + 16'(k));
      model[8'h40 + 8'(k)] = 16'h5B00 + 16'(k);
    end
    check_bit("R6", busy, 1'b0);
    cyc(P_NOP, 8'h00, 16'hBAD1);
    check_all("R6 R7 gap1");
  endtask

  // R6: interrupt after two words, new burst wraps
  task automatic t_gap2;
    logic [7:0] cols [4] = '{8'h67, 8'h64, 8'h65, 8'h66};
    blen_sel = 2'd2;
    cyc(P_WR,  8'h50, 16'h6A00); model[8'h50] = 16'h6A00;
    cyc(P_NOP, 8'h00, 16'h6A01); model[8'h51] = 16'h6A01;
    for (int k = 0; k < 4; k++) begin
      cyc(k == 0 ? P_WR : P_NOP, 8'h67, 16'h6B00 + 16'(k));
      model[cols[k]] = 16'h6B00 + 16'(k);
    end
    check_all("R6 gap2");
  endtask

  // R8: non-write commands mid-burst keep it running
  task automatic t_nowrite_mid;
    logic [3:0] pats [3] = '{P_RD, P_DESEL, P_ACT};
    blen_sel = 2'd2;
    cyc(P_WR, 8'h80, 16'h7000); model[8'h80] = 16'h7000;
    for (int k = 0; k < 3; k++) begin
      cyc(pats[k], 8'hF0, 16'h7001 + 16'(k));
      model[8'h81 + 8'(k)] = 16'h7001 + 16'(k);
    end
    check_bit("R8", busy, 1'b0);
    check_all("R8 mid");
  endtask

  // R1: idle non-write patterns store nothing
  task automatic t_idle_decode;
    logic [3:0] pats [5] = '{P_DESEL, P_RD, P_ACT, P_PRE, P_NOP};
    blen_sel = 2'd3;
    for (int k = 0; k < 5; k++) cyc(pats[k], 8'h90, 16'hBAD2);
    check_bit("R1", busy, 1'b0);
    check_all("R1 idle");
  endtask

  // R9: lengths 1, 2 and 8
  task automatic t_lengths;
    logic [7:0] c8 [8] = '{8'hBD, 8'hBE, 8'hBF, 8'hB8, 8'hB9, 8'hBA, 8'hBB, 8'hBC};
    blen_sel = 2'd0;
    cyc(P_WR, 8'hA3, 16'h8000); model[8'hA3] = 16'h8000;
    check_bit("R9", busy, 1'b0);
    cyc(P_NOP, 8'h00, 16'hBAD3);
    blen_sel = 2'd1;
    cyc(P_WR,  8'hA9, 16'h8100); model[8'hA9] = 16'h8100;
    cyc(P_NOP, 8'h00, 16'h8101); model[8'hA8] = 16'h8101;
    cyc(P_NOP, 8'h00, 16'hBAD4);
    blen_sel = 2'd3;
    for (int k = 0; k < 8; k++) begin
      cyc(k == 0 ? P_WR : P_NOP, 8'hBD, 16'h8200 + 16'(k));
      model[c8[k]] = 16'h8200 + 16'(k);
    end
    check_all("R9 lengths");
  endtask

  // R10: reset stops a burst and keeps the array
  task automatic t_reset_mid;
    blen_sel = 2'd3;
    cyc(P_WR,  8'hC0, 16'h9000); model[8'hC0] = 16'h9000;
    cyc(P_NOP, 8'h00, 16'h9001); model[8'hC1] = 16'h9001;
    rst = 1'b1;
    cyc(P_NOP, 8'h00, 16'hBAD5);
    check_bit("R10", busy, 1'b0);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) cyc(P_NOP, 8'h00, 16'hBAD6);
    check_bit("R10", busy, 1'b0);
    check_all("R10 reset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    col_addr = '0; dq_in = '0; blen_sel = 2'd2; rd_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check_bit("R10", busy, 1'b0);
    rst = 1'b0;
    t_fill();
    t_bl4_wrap();
    t_gap1();
    t_gap2();
    t_nowrite_mid();
    t_idle_decode();
    t_lengths();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule